// File: doc/BRIEF.md
# Asymmetric Flash Block Lock Manager

This block sits beside the command logic of a word-addressed flash array. The array holds 2M words of 16 bits. It is split into 63 large blocks of 32K words and 8 small blocks of 4K words. A build-time parameter puts the eight small blocks either in the highest 32K words of the space or in the lowest 32K words. The manager turns a query address into the index of the erase block that holds it, and keeps a protection state for every block. A registered permit bit tells the program/erase path whether an operation aimed at the queried block may go ahead.

Every block runs a small three-state machine. The state names are UNLOCKED (`LK_OPEN`), LOCKED (`LK_SHUT`) and LOCKED-DOWN (`LK_PINNED`). The transitions are:

- lock: OPEN→SHUT.
- unlock: SHUT→OPEN.
- pin: any state→PINNED.
- release-lock: PINNED→SHUT, only while `wp_n` is high.
- release-unlock: PINNED→OPEN, only while `wp_n` is high.
- hold: no change for any other input.

Reset forces every machine to SHUT. A command is given by a one-cycle strobe together with `cmd_addr`, and it takes effect at the next clock edge. A low-programming-voltage flag blocks the permit for every block, whatever its state.

Top module: `flash_lock_guard`

## Requirements
- R1: With the small blocks on top (`SMALL_AT_TOP=1`), an address below 0x1F8000 gives `blk_idx` = address/32768 (0..62). With the small blocks at the bottom, an address of 0x8000 or more gives `blk_idx` = 7 + address/32768 (8..70). `blk_idx` is combinational from `addr`.
- R2: Small-block decode. With the small blocks on top, an address of 0x1F8000 or more gives `blk_idx` = 63 + (address−0x1F8000)/4096. With them at the bottom, an address below 0x8000 gives `blk_idx` = address/4096.
- R3: While `rst_n` is low, and after it rises, every block reads as locked (`lock_state`=2'b01) until a command changes it. Reset also clears the locked-down state.
- R4: A `lock_stb` on an unlocked block makes it locked (2'b01) from the next edge.
- R5: An `unlock_stb` on a locked block makes it unlocked (2'b00) from the next edge.
- R6: A `lockdown_stb` makes the addressed block locked-down (2'b10) from any state.
- R7: While `wp_n` is low, lock and unlock strobes leave a locked-down block unchanged.
- R8: While `wp_n` is high, lock and unlock strobes take a locked-down block to locked or unlocked, the same as for a non-pinned block.
- R9: While `vpp_low` is high at a clock edge, `permit` is 0 after that edge.
- R10: At each edge, `lock_state` and `permit` register the state of block `blk_idx` as it was before that edge's command. `permit`=1 exactly when that state is unlocked and `vpp_low` was low. Code 2'b11 never appears.
- R11: When strobes coincide on one block, lock-down wins over lock, and lock wins over unlock.
- R12: A command changes only the block that `cmd_addr` decodes to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset / power-up |
| addr | input | 21 | Query word address |
| cmd_addr | input | 21 | Target word address of a lock command |
| lock_stb | input | 1 | Lock command strobe |
| unlock_stb | input | 1 | Unlock command strobe |
| lockdown_stb | input | 1 | Lock-down command strobe |
| wp_n | input | 1 | Write-protect pin, low = protect lock-down |
| vpp_low | input | 1 | Programming voltage below lockout level |
| blk_idx | output | 7 | Block index of `addr` |
| lock_state | output | 2 | Registered state of the queried block |
| permit | output | 1 | Registered program/erase permission |

## Verification
The bench drives both placements side by side. It looks hardest at the seam addresses 0x1F7FFF/0x1F8000 and 0x7FFF/0x8000. A decoder with an off-by-one there would send small-block addresses to a large block, or shift every index by one. Directed cases pin a block with `wp_n` low and then try to unlock it. A design that ignores the pin would raise `permit`. The same cases raise `wp_n` and try again, where a design that never releases a pin would stay stuck. Reset is applied in the middle of a run to show that pins clear. Coincident strobes are issued to expose a wrong priority. Random traffic, weighted toward a few blocks, catches commands that leak into neighbouring blocks and a permit that is taken one cycle too late or too early.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
    typedef enum logic [1:0] {
        LK_OPEN   = 2'b00,
        LK_SHUT   = 2'b01,
        LK_PINNED = 2'b10
    } lock_e;
endpackage

// File: rtl/flash_blk_decode.sv
module flash_blk_decode #(
    parameter int ADDR_W       = 21,
    parameter int BIG_W        = 15,
    parameter int SMALL_W      = 12,
    parameter bit SMALL_AT_TOP = 1'b1,
    parameter int IDX_W        = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int HI_W    = ADDR_W - BIG_W;
    localparam int SUB_W   = BIG_W - SMALL_W;
    localparam int N_BIG   = (1 << HI_W) - 1;
    localparam int N_SMALL = 1 << SUB_W;

    logic [HI_W-1:0]  hi;
    logic [SUB_W-1:0] sub;

    assign hi  = addr[ADDR_W-1:BIG_W];
    assign sub = addr[BIG_W-1:SMALL_W];

    generate
        if (SMALL_AT_TOP) begin : g_top
            always_comb begin
                if (hi == {HI_W{1'b1}})
                    idx = IDX_W'(N_BIG) + IDX_W'(sub);
                else
                    idx = IDX_W'(hi);
            end
        end else begin : g_bottom
            always_comb begin
                if (hi == '0)
                    idx = IDX_W'(sub);
                else
                    idx = IDX_W'(N_SMALL - 1) + IDX_W'(hi);
            end
        end
    endgenerate
endmodule

// File: rtl/flash_lock_cell.sv
module flash_lock_cell
    import flash_lock_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sel,
    input  logic  lock_cmd,
    input  logic  unlock_cmd,
    input  logic  pin_cmd,
    input  logic  wp_n,
    output lock_e state
);
    lock_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LK_SHUT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (sel) begin
            unique case (state)
                LK_OPEN: begin
                    if (pin_cmd)       nxt = LK_PINNED;
                    else if (lock_cmd) nxt = LK_SHUT;
                end
                LK_SHUT: begin
                    if (pin_cmd)         nxt = LK_PINNED;
                    else if (lock_cmd)   nxt = LK_SHUT;
                    else if (unlock_cmd) nxt = LK_OPEN;
                end
                LK_PINNED: begin
                    if (pin_cmd)                 nxt = LK_PINNED;
                    else if (wp_n && lock_cmd)   nxt = LK_SHUT;
                    else if (wp_n && unlock_cmd) nxt = LK_OPEN;
                end
                default: nxt = LK_SHUT;
            endcase
        end
    end
endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
    import flash_lock_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int BIG_W        = 15,
    parameter int SMALL_W      = 12,
    parameter bit SMALL_AT_TOP = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              lock_stb,
    input  logic              unlock_stb,
    input  logic              lockdown_stb,
    input  logic              wp_n,
    input  logic              vpp_low,
    output logic [6:0]        blk_idx,
    output logic [1:0]        lock_state,
    output logic              permit
);
    localparam int N_BLK = (1 << (ADDR_W - BIG_W)) - 1 + (1 << (BIG_W - SMALL_W));
    localparam int IDX_W = 7;

    logic [IDX_W-1:0] q_idx;
    logic [IDX_W-1:0] cmd_idx;
    lock_e            st [N_BLK];
    lock_e            q_st;
    lock_e            state_q;
    logic             permit_q;

    flash_blk_decode #(
        .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
        .SMALL_AT_TOP(SMALL_AT_TOP), .IDX_W(IDX_W)
    ) u_qdec (.addr(addr), .idx(q_idx));

    flash_blk_decode #(
        .ADDR_W(ADDR_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W),
        .SMALL_AT_TOP(SMALL_AT_TOP), .IDX_W(IDX_W)
    ) u_cdec (.addr(cmd_addr), .idx(cmd_idx));

    generate
        for (genvar g = 0; g < N_BLK; g++) begin : g_cell
            flash_lock_cell u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel       (cmd_idx == IDX_W'(g)),
                .lock_cmd  (lock_stb),
                .unlock_cmd(unlock_stb),
                .pin_cmd   (lockdown_stb),
                .wp_n      (wp_n),
                .state     (st[g])
            );
        end
    endgenerate

    assign q_st = st[q_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= LK_SHUT;
            permit_q <= 1'b0;
        end else begin
            state_q  <= q_st;
            permit_q <= (q_st == LK_OPEN) && !vpp_low;
        end
    end

    assign blk_idx    = q_idx;
    assign lock_state = state_q;
    assign permit     = permit_q;
endmodule

// File: rtl/flash_lock_guard_chk.sv
module flash_lock_guard_chk #(
    parameter int N_BLK = 71
) (
    input logic       clk,
    input logic       rst_n,
    input logic [6:0] blk_idx,
    input logic [6:0] cmd_idx,
    input logic       lockdown_stb,
    input logic       vpp_low,
    input logic [1:0] lock_state,
    input logic       permit
);
    // R1
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(blk_idx) < N_BLK);

    // R3
    reset_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> lock_state == 2'b01);

    // R6
    pin_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockdown_stb && cmd_idx == blk_idx) ##1 (blk_idx == $past(blk_idx))
        |=> lock_state == 2'b10);

    // R9
    vpp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_low |=> !permit);

    // R10
    permit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        permit |-> lock_state == 2'b00);

    // R10
    state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_state != 2'b11);
endmodule

bind flash_lock_guard flash_lock_guard_chk #(.N_BLK(N_BLK)) u_chk (
    .clk(clk), .rst_n(rst_n), .blk_idx(blk_idx), .cmd_idx(cmd_idx),
    .lockdown_stb(lockdown_stb), .vpp_low(vpp_low),
    .lock_state(lock_state), .permit(permit)
);

// File: tb/sim_flash_lock_guard.sv
`timescale 1ns/1ps
module sim_flash_lock_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] addr = '0;
    logic [20:0] cmd_addr = '0;
    logic        lock_stb = 1'b0, unlock_stb = 1'b0, lockdown_stb = 1'b0;
    logic        wp_n = 1'b0, vpp_low = 1'b0;
    logic [6:0]  idx_t, idx_b;
    logic [1:0]  st_t, st_b;
    logic        pm_t, pm_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mdl [2][71];   // [0]=top placement, [1]=bottom; 0 open,1 shut,2 pinned

    always #2 clk = ~clk;

    flash_lock_guard #(.SMALL_AT_TOP(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cmd_addr(cmd_addr),
        .lock_stb(lock_stb), .unlock_stb(unlock_stb), .lockdown_stb(lockdown_stb),
        .wp_n(wp_n), .vpp_low(vpp_low), .blk_idx(idx_t), .lock_state(st_t), .permit(pm_t));

    flash_lock_guard #(.SMALL_AT_TOP(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cmd_addr(cmd_addr),
        .lock_stb(lock_stb), .unlock_stb(unlock_stb), .lockdown_stb(lockdown_stb),
        .wp_n(wp_n), .vpp_low(vpp_low), .blk_idx(idx_b), .lock_state(st_b), .permit(pm_b));

    function automatic int ref_idx(input int a, input int top);
        if (top != 0) begin
            if (a >= 32'h1F8000) return 63 + (a - 32'h1F8000) / 4096;
            return a / 32768;
        end
        if (a < 32768) return a / 4096;
        return 7 + a / 32768;
    endfunction

    function automatic int next_st(input int cur, input bit lk, input bit ul,
                                   input bit ld, input bit w);
        if (ld) return 2;
        if (cur == 2 && !w) return 2;
        if (lk) return 1;
        if (ul) return 0;
        return cur;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < 71; b++) mdl[p][b] = 1;
    endtask

    // Called at a negedge; returns at the next negedge.
    task automatic cycle(input int a, input int ca, input bit lk, input bit ul,
                         input bit ld, input bit w, input bit v, input string tag);
        int ei [2];
        int es [2];
        int ci;
        addr = 21'(a); cmd_addr = 21'(ca);
        lock_stb = lk; unlock_stb = ul; lockdown_stb = ld; wp_n = w; vpp_low = v;
        #1;
        ei[0] = ref_idx(a, 1);
        ei[1] = ref_idx(a, 0);
        chk((ei[0] >= 63) ? "R2 top idx" : "R1 top idx", int'(idx_t), ei[0]);
        chk((ei[1] <= 7)  ? "R2 bot idx" : "R1 bot idx", int'(idx_b), ei[1]);
        for (int p = 0; p < 2; p++) begin
            es[p] = mdl[p][ei[p]];
            ci = ref_idx(ca, 1 - p);
            if (lk || ul || ld) mdl[p][ci] = next_st(mdl[p][ci], lk, ul, ld, w);
        end
        @(negedge clk);
        chk(tag, int'(st_t), es[0]);
        chk(tag, int'(st_b), es[1]);
        chk(v ? "R9" : "R10", int'(pm_t), (es[0] == 0 && !v) ? 1 : 0);
        chk(v ? "R9" : "R10", int'(pm_b), (es[1] == 0 && !v) ? 1 : 0);
        lock_stb = 0; unlock_stb = 0; lockdown_stb = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lock_stb = 0; unlock_stb = 0; lockdown_stb = 0;
        #1;
        chk("R3 in reset", int'(st_t), 1);
        chk("R3 in reset", int'(pm_t), 0);
        model_reset();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        int blk_a, blk_s, ra, rc;
        void'($urandom(32'd5150));
        model_reset();
        do_reset();
        // R3: all blocks locked after reset
        for (int b = 0; b < 64; b++) cycle(b * 32768 + 5, 0, 0, 0, 0, 0, 0, "R3");
        for (int s = 0; s < 8; s++) cycle(32'h1F8000 + s * 4096, 0, 0, 0, 0, 0, 0, "R3");
        // seam addresses for decode (R1, R2)
        cycle(32'h1F7FFF, 0, 0, 0, 0, 0, 0, "R1");
        cycle(32'h1F8000, 0, 0, 0, 0, 0, 0, "R2");
        cycle(32'h7FFF, 0, 0, 0, 0, 0, 0, "R2");
        cycle(32'h8000, 0, 0, 0, 0, 0, 0, "R1");
        cycle(32'h1FFFFF, 0, 0, 0, 0, 0, 0, "R2");
        blk_a = 5 * 32768 + 77;
        blk_s = 32'h1FF123;
        // R5 unlock, R12 neighbour untouched
        cycle(blk_a, blk_a, 0, 1, 0, 0, 0, "R5");
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R5");
        cycle(blk_a + 32768, 0, 0, 0, 0, 0, 0, "R12");
        cycle(blk_a - 32768, 0, 0, 0, 0, 0, 0, "R12");
        // R9 voltage lockout on an open block
        cycle(blk_a, 0, 0, 0, 0, 0, 1, "R9");
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R9");
        // R4 lock
        cycle(blk_a, blk_a, 1, 0, 0, 0, 0, "R4");
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R4");
        // R6 pin from open and from shut
        cycle(blk_s, blk_s, 0, 1, 0, 0, 0, "R5");
        cycle(blk_s, blk_s, 0, 0, 1, 0, 0, "R6");
        cycle(blk_s, 0, 0, 0, 0, 0, 0, "R6");
        cycle(blk_a, blk_a, 0, 0, 1, 0, 0, "R6");
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R6");
        // R7 wp low holds pin
        cycle(blk_a, blk_a, 0, 1, 0, 0, 0, "R7");
        cycle(blk_a, blk_a, 1, 0, 0, 0, 0, "R7");
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R7");
        // R8 wp high releases
        cycle(blk_a, blk_a, 0, 1, 0, 1, 0, "R8");
        cycle(blk_a, 0, 0, 0, 0, 1, 0, "R8");
        cycle(blk_s, blk_s, 1, 0, 0, 1, 0, "R8");
        cycle(blk_s, 0, 0, 0, 0, 1, 0, "R8");
        // R11 priority
        cycle(blk_a, blk_a, 1, 1, 0, 1, 0, "R11");
        cycle(blk_a, blk_a, 1, 1, 1, 1, 0, "R11");
        cycle(blk_a, 0, 0, 0, 0, 1, 0, "R11");
        // R3 reset mid-run clears pin
        do_reset();
        cycle(blk_a, 0, 0, 0, 0, 0, 0, "R3");
        cycle(blk_s, 0, 0, 0, 0, 0, 0, "R3");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int k;
            k = int'($urandom_range(0, 3));
            ra = (k == 0) ? int'(32'h1F8000 + $urandom_range(0, 32767))
               : (k == 1) ? int'($urandom_range(0, 32767))
               : int'($urandom_range(0, 32'h1FFFFF));
            rc = int'($urandom_range(0, 5)) * 32768 + int'($urandom_range(0, 32767));
            if ($urandom_range(0, 3) == 0) rc = int'(32'h1F8000 + $urandom_range(0, 32767));
            if ($urandom_range(0, 1) == 0) ra = rc;
            cycle(ra, rc, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 15) == 0), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 7) == 0), "R12");
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule